// File: doc/BRIEF.md
# Fibonacci Pattern-Free Bus Codec

This block protects a wide on-chip parallel bus against worst-case capacitive coupling delay. A binary word is mapped onto a wider codeword whose digits are weighted by Fibonacci numbers. The mapping is chosen so that no wire ever sits between two neighbours that both hold the opposite value. Because the bus never carries 010 or 101 across three adjacent wires, the slowest switching case disappears without inserting shield wires.

The encoder is a chain of one comparator-and-subtractor stage per code digit, run from the most significant digit downwards. Each stage makes one of three decisions. A large remainder forces a one and a small remainder forces a zero. A remainder between the two limits repeats the digit chosen by the stage above, and this repetition is what keeps the codeword free of isolated digits. The decoder is memoryless: it adds the weights of the set digits of the word it receives now. Words that the code width cannot represent raise a flag and produce an all-zero codeword. Both paths can end in an output register.

Top module: `fib_fpf_codec`

## Requirements
- R1: `dec_data_o` equals the sum of f_k over every set bit k-1 of `dec_code_i` (bit 0 carries f_1), where f_1 = f_2 = 1 and f_k = f_(k-1) + f_(k-2), truncated to DATA_W bits.
- R2: For every input with `enc_oor_o` low, no three adjacent bits of `enc_code_o` read 010 or 101.
- R3: For every input below f_(CODE_W+2), decoding `enc_code_o` by the weighting of R1 returns the input word.
- R4: `enc_oor_o` is high exactly when the input is at least f_(CODE_W+2), and `enc_code_o` is then all zeros.
- R5: For an in-range input, the top code bit is one exactly when the input is at least f_(CODE_W+1).
- R6: A remainder lying from f_k up to f_(k+1)-1 at stage k repeats the stage above; with CODE_W = 7 the input 19 therefore encodes to 0111110 (bit 6 first).
- R7: With REG_OUT = 1, each output shows the result for the input present one rising edge earlier and keeps its previous value until that edge.
- R8: While `rst` is high at a rising edge, `enc_code_o`, `enc_oor_o` and `dec_data_o` are cleared to zero when REG_OUT = 1.
- R9: Every codeword that represents the same value decodes to it; with CODE_W = 7 all of 0111101, 0111110, 1001101, 1001110, 1010001 and 1010010 decode to 19.
- R10: Two codewords that differ only by swapping their lowest two bits, 01 against 10, decode to the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | DATA_W | Binary word to encode |
| enc_code_o | output | CODE_W | Pattern-free Fibonacci codeword |
| enc_oor_o | output | 1 | Input cannot be represented in CODE_W digits |
| dec_code_i | input | CODE_W | Received codeword |
| dec_data_o | output | DATA_W | Recovered binary word |

## Verification
The encoder assertions assume that `enc_data_i` is fully driven and held steady across each sampling edge; the bench changes it only on the falling edge and gives it a defined value before reset is released. The register checks assume the encoder and decoder inputs carry no unknown bits after reset, which the bench ensures by driving both paths on every cycle. The decoder accepts any codeword, including ones that contain forbidden patterns, so random codes are applied to it without constraint. Encoder inputs are swept over the whole DATA_W range, with the out-of-range portion included on purpose.

// File: rtl/fib_codec_pkg.sv
package fib_codec_pkg;

  // Fibonacci number with f(0)=0, f(1)=f(2)=1.
  function automatic logic [63:0] fib_num(input int k);
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] t;
    a = 64'd0;
    b = 64'd1;
    for (int i = 0; i < k; i++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  // True if any window of three adjacent bits in the low 'width' bits is 010 or 101.
  function automatic logic has_isolated_bit(input logic [63:0] v, input int width);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i + 2 < width; i++) begin
      if ((v[i] != v[i+1]) && (v[i+1] != v[i+2])) bad = 1'b1;
    end
    return bad;
  endfunction

endpackage

// File: rtl/fib_enc_stage.sv
module fib_enc_stage
  import fib_codec_pkg::*;
#(
  parameter int W      = 6,
  parameter int K      = 2,
  parameter bit IS_TOP = 1'b0
) (
  input  logic [W-1:0] rem_i,
  input  logic         above_i,
  output logic         bit_o,
  output logic [W-1:0] rem_o
);
  localparam logic [63:0] F_LO = fib_num(K);
  localparam logic [63:0] F_HI = fib_num(K + 1);

  logic [63:0] rem_x;

  always_comb begin
    rem_x = 64'(rem_i);
    if (IS_TOP) begin
      bit_o = (rem_x >= F_HI);
    end else if (rem_x >= F_HI) begin
      bit_o = 1'b1;
    end else if (rem_x < F_LO) begin
      bit_o = 1'b0;
    end else begin
      bit_o = above_i;
    end
    rem_o = bit_o ? (rem_i - W'(F_LO)) : rem_i;
  end
endmodule

// File: rtl/fib_encoder.sv
module fib_encoder
  import fib_codec_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int CODE_W = 7
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              oor_o,
  output logic [DATA_W-1:0] resid_o
);
  localparam logic [63:0] F_LIMIT = fib_num(CODE_W + 2);

  logic [DATA_W-1:0] rem [0:CODE_W];
  logic [CODE_W-1:0] dig;

  assign rem[CODE_W] = data_i;

  for (genvar k = CODE_W; k >= 1; k--) begin : g_stage
    if (k == CODE_W) begin : g_top
      fib_enc_stage #(.W(DATA_W), .K(k), .IS_TOP(1'b1)) u_stage (
        .rem_i  (rem[k]),
        .above_i(1'b0),
        .bit_o  (dig[k-1]),
        .rem_o  (rem[k-1])
      );
    end else begin : g_mid
      fib_enc_stage #(.W(DATA_W), .K(k), .IS_TOP(1'b0)) u_stage (
        .rem_i  (rem[k]),
        .above_i(dig[k]),
        .bit_o  (dig[k-1]),
        .rem_o  (rem[k-1])
      );
    end
  end

  assign oor_o   = (64'(data_i) >= F_LIMIT);
  assign code_o  = oor_o ? '0 : dig;
  assign resid_o = rem[0];
endmodule

// File: rtl/fib_decoder.sv
module fib_decoder
  import fib_codec_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int CODE_W = 7
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 1; k <= CODE_W; k++) begin
      if (code_i[k-1]) data_o = data_o + DATA_W'(fib_num(k));
    end
  end
endmodule

// File: rtl/fib_fpf_codec.sv
module fib_fpf_codec
  import fib_codec_pkg::*;
#(
  parameter int DATA_W  = 6,
  parameter int CODE_W  = 7,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CODE_W-1:0] enc_code_o,
  output logic              enc_oor_o,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic [DATA_W-1:0] dec_data_o
);
  localparam logic [63:0] F_MSB = fib_num(CODE_W + 1);

  logic [CODE_W-1:0] enc_code_c;
  logic              enc_oor_c;
  logic [DATA_W-1:0] enc_resid_c;
  logic [DATA_W-1:0] dec_data_c;

  fib_encoder #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_c),
    .oor_o  (enc_oor_c),
    .resid_o(enc_resid_c)
  );

  fib_decoder #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_dec (
    .code_i(dec_code_i),
    .data_o(dec_data_c)
  );

  // Encoder properties
  p_no_isolated_r2: assert property (@(posedge clk) disable iff (rst)
    !enc_oor_c |-> !has_isolated_bit(64'(enc_code_c), CODE_W));

  p_resid_empty_r3: assert property (@(posedge clk) disable iff (rst)
    !enc_oor_c |-> (enc_resid_c == '0));

  p_oor_zero_r4: assert property (@(posedge clk) disable iff (rst)
    enc_oor_c |-> (enc_code_c == '0));

  p_msb_split_r5: assert property (@(posedge clk) disable iff (rst)
    !enc_oor_c |-> (enc_code_c[CODE_W-1] == (64'(enc_data_i) >= F_MSB)));

  if (REG_OUT) begin : g_reg
    logic [CODE_W-1:0] code_q;
    logic              oor_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= '0;
        oor_q  <= 1'b0;
        data_q <= '0;
      end else begin
        code_q <= enc_code_c;
        oor_q  <= enc_oor_c;
        data_q <= dec_data_c;
      end
    end

    assign enc_code_o = code_q;
    assign enc_oor_o  = oor_q;
    assign dec_data_o = data_q;

    p_enc_latency_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (enc_code_o == $past(enc_code_c)) && (enc_oor_o == $past(enc_oor_c)));

    p_dec_latency_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (dec_data_o == $past(dec_data_c)));

    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (enc_code_o == '0) && !enc_oor_o && (dec_data_o == '0));
  end else begin : g_comb
    assign enc_code_o = enc_code_c;
    assign enc_oor_o  = enc_oor_c;
    assign dec_data_o = dec_data_c;
  end
endmodule

// File: tb/tb_fib_fpf_codec.sv
module tb_fib_fpf_codec;
  localparam int DATA_W = 6;
  localparam int CODE_W = 7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] enc_data_i = '0;
  logic [CODE_W-1:0] enc_code_o;
  logic              enc_oor_o;
  logic [CODE_W-1:0] dec_code_i = '0;
  logic [DATA_W-1:0] dec_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  fib_fpf_codec #(.DATA_W(DATA_W), .CODE_W(CODE_W), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst),
    .enc_data_i(enc_data_i), .enc_code_o(enc_code_o), .enc_oor_o(enc_oor_o),
    .dec_code_i(dec_code_i), .dec_data_o(dec_data_o)
  );

  always #4 clk = ~clk;

  function automatic int fb(input int k);
    int a, b, t;
    a = 0; b = 1;
    for (int i = 0; i < k; i++) begin t = a + b; a = b; b = t; end
    return a;
  endfunction

  function automatic int bdec(input logic [CODE_W-1:0] c);
    int s;
    s = 0;
    for (int k = 1; k <= CODE_W; k++) if (c[k-1]) s += fb(k);
    return s % (1 << DATA_W);
  endfunction

  function automatic bit isolated(input logic [CODE_W-1:0] c);
    bit bad;
    bad = 1'b0;
    for (int i = 0; i + 2 < CODE_W; i++)
      if ((c[i] != c[i+1]) && (c[i+1] != c[i+2])) bad = 1'b1;
    return bad;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge, then look at the registered result one edge later.
  task automatic apply(input int d, input logic [CODE_W-1:0] c);
    @(negedge clk);
    enc_data_i = DATA_W'(d);
    dec_code_i = c;
    @(negedge clk);
  endtask

  task automatic check_enc(input int x);
    int lim;
    lim = fb(CODE_W + 2);
    if (x >= lim) begin
      chk(enc_oor_o == 1'b1, "R4 flag", int'(enc_oor_o), 1);
      chk(enc_code_o == '0, "R4 zero code", int'(enc_code_o), 0);
    end else begin
      chk(enc_oor_o == 1'b0, "R4 flag low", int'(enc_oor_o), 0);
      chk(!isolated(enc_code_o), "R2 pattern free", int'(enc_code_o), 0);
      chk(bdec(enc_code_o) == x, "R3 round trip", bdec(enc_code_o), x);
      chk(enc_code_o[CODE_W-1] == (x >= fb(CODE_W + 1)), "R5 top digit",
          int'(enc_code_o[CODE_W-1]), int'(x >= fb(CODE_W + 1)));
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [CODE_W-1:0] eqv [6];
    int unsigned seed;
    seed = $urandom(32'd4242);
    eqv[0] = 7'b0111101; eqv[1] = 7'b0111110; eqv[2] = 7'b1001101;
    eqv[3] = 7'b1001110; eqv[4] = 7'b1010001; eqv[5] = 7'b1010010;

    // R8: reset with live inputs
    enc_data_i = 6'd19;
    dec_code_i = 7'h7F;
    repeat (3) @(negedge clk);
    chk(enc_code_o == '0, "R8 code reset", int'(enc_code_o), 0);
    chk(enc_oor_o == 1'b0, "R8 flag reset", int'(enc_oor_o), 0);
    chk(dec_data_o == '0, "R8 data reset", int'(dec_data_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // R6: grey-zone copy gives 0111110 for 19
    chk(enc_code_o == 7'b0111110, "R6 encode 19", int'(enc_code_o), 62);
    chk(dec_data_o == 6'd33, "R1 all ones", int'(dec_data_o), 33);

    // R7: one-edge latency
    enc_data_i = 6'd5;
    dec_code_i = 7'b0000011;
    #1;
    chk(enc_code_o == 7'b0111110, "R7 enc holds", int'(enc_code_o), 62);
    chk(dec_data_o == 6'd33, "R7 dec holds", int'(dec_data_o), 33);
    @(negedge clk);
    chk(bdec(enc_code_o) == 5, "R7 enc updates", bdec(enc_code_o), 5);
    chk(dec_data_o == 6'd2, "R7 dec updates", int'(dec_data_o), 2);

    // R2 R3 R4 R5: full sweep of the input range
    for (int x = 0; x < (1 << DATA_W); x++) begin
      apply(x, CODE_W'(x));
      check_enc(x);
      chk(int'(dec_data_o) == bdec(CODE_W'(x)), "R1 sweep", int'(dec_data_o), bdec(CODE_W'(x)));
    end

    // R9: all equivalent forms of 19
    for (int i = 0; i < 6; i++) begin
      apply(19, eqv[i]);
      chk(dec_data_o == 6'd19, "R9 equivalent", int'(dec_data_o), 19);
    end

    // R1 and encoder with random stimulus
    for (int i = 0; i < 300; i++) begin
      int d;
      logic [CODE_W-1:0] c;
      d = int'($urandom % (1 << DATA_W));
      c = CODE_W'($urandom);
      apply(d, c);
      check_enc(d);
      chk(int'(dec_data_o) == bdec(c), "R1 random", int'(dec_data_o), bdec(c));
    end

    // R10: lowest two bits swapped decode alike
    for (int i = 0; i < 40; i++) begin
      logic [CODE_W-1:0] c;
      int first;
      c = CODE_W'($urandom);
      c[1:0] = 2'b01;
      apply(0, c);
      first = int'(dec_data_o);
      c[1:0] = 2'b10;
      apply(0, c);
      chk(int'(dec_data_o) == first, "R10 low swap", int'(dec_data_o), first);
    end

    // R4 boundary: last legal and first illegal value
    apply(fb(CODE_W + 2) - 1, '0);
    check_enc(fb(CODE_W + 2) - 1);
    apply(fb(CODE_W + 2), '0);
    check_enc(fb(CODE_W + 2));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule